// File: doc/BRIEF.md
# Level-Sensitive DMA Request Acceptance Controller

This block sits beside one DMA channel and decides when an external, level-sensitive transfer request is taken. The active-low request pin is first synchronised. Once the channel is enabled, the pin is sampled on every clock edge while acceptance is open. A low sample becomes a pending request, held for exactly one cycle. The pending flag clears as the controller activates the transfer and asks for the bus. With the bus granted, the controller issues one read strobe and then one write strobe. That pair is one transfer.

While a transfer is in flight, acceptance is closed so that the still-low pin cannot be counted twice. A per-channel delay bit keeps acceptance closed for one more cycle after each write. Between the last write strobe and the next read strobe the bus stays free for at least `MIN_REL` cycles. A loaded transfer count falls by one on every write. When it reaches zero the channel disables itself, pulses `done` and stops sampling.

The FSM states are IDLE, SAMPLE, HOLD, WAIT, READ, WRITE and EXTEND. The transitions are:
- IDLE→SAMPLE when the channel is enabled.
- SAMPLE→HOLD on a low synchronised sample.
- HOLD→WAIT always, or to IDLE if disabled.
- WAIT→READ on grant, or to IDLE if disabled.
- READ→WRITE on the read strobe.
- WRITE→IDLE on the last write, or on any write while disabled.
- WRITE→EXTEND on a write when the delay bit is 1.
- WRITE→SAMPLE on a write when the delay bit is 0.
- EXTEND→SAMPLE, or to IDLE if disabled.

Top module: `dreq_accept_ctrl`

## Requirements
- R1: After reset, `enabled`=0, `remain`=0, `pend`=0 and `bus_req`, `rd_stb`, `wr_stb` and `done` are all 0.
- R2: A control write (`ctl_wr`=1) with `ctl_en`=0 clears `enabled`. It takes effect in the next cycle. A write with `ctl_en`=1 sets `enabled` and loads `remain` from `ctl_count` only when the channel is disabled and `ctl_count` is nonzero. Otherwise such a write is ignored.
- R3: `req_n` passes through a 2-stage synchroniser. In a cycle where acceptance is open, a low synchronised level raises `pend` in the next cycle. `pend` stays high for exactly one cycle, and `bus_req` rises in the cycle after it.
- R4: A low level on `req_n` whose synchronised copy falls only inside the clearance window is never latched. The window runs from the `pend` cycle through the write cycle, plus the extension cycle when the delay bit is set.
- R5: Each transfer is one `rd_stb` cycle followed later by one `wr_stb` cycle. A strobe is high only while `bus_grant` is high. `bus_req` is high from activation until the write strobe.
- R6: With `ctl_dly`=0, sampling resumes in the cycle right after the write. With `ctl_dly`=1, it resumes one cycle later. With the request held low and grant held high, the next read comes 4 cycles after a write when `ctl_dly`=0, and 5 cycles after when `ctl_dly`=1.
- R7: At least `MIN_REL` cycles with neither strobe lie between a `wr_stb` and the next `rd_stb`.
- R8: `remain` falls by one after each write. The write that brings it to zero also raises `done` for one cycle. In the next cycle `enabled` is 0, and no further transfer follows.
- R9: If the channel is disabled once the read state is reached, the read/write pair still completes and the controller then goes idle. If it is disabled before that, the controller drops the pending activation and returns to idle without strobing.
- R10: `rst` is synchronous and active high, and applies the state of R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 1 | Asynchronous level-sensitive transfer request, active low |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_en | input | 1 | Enable value written by `ctl_wr` |
| ctl_dly | input | 1 | Extend the clearance window by one cycle |
| ctl_count | input | CNT_W | Transfer count loaded on enable |
| bus_grant | input | 1 | Bus grant for the channel |
| bus_req | output | 1 | Bus request for the channel |
| rd_stb | output | 1 | One-cycle source read strobe |
| wr_stb | output | 1 | One-cycle destination write strobe |
| done | output | 1 | Pulse on the final write |
| pend | output | 1 | Pending request is held |
| enabled | output | 1 | Channel enable state |
| remain | output | CNT_W | Transfers still to perform |

## Verification
The bench builds the block with `CNT_W`=16, `MIN_REL`=3 and a 2-stage synchroniser. At these values a request held low runs back to back with a write-to-read spacing of 4 or 5 cycles, so the delay bit and the bus-free gap are both observed exactly. Counts of 1 to 5 make the terminal-count path, the zero-count load and mid-transfer disabling reachable within a few dozen cycles. A behavioural model compares every output on every cycle. Grant patterns that stall both the read and the write exercise the strobe gating.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_HOLD,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_EXTEND
    } dreq_state_e;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '1;
                else     sh <= {sh[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sh[STAGES-1];
endmodule

// File: rtl/dreq_count.sv
module dreq_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic [CNT_W-1:0] ctl_count,
    input  logic             xfer_done,
    output logic             en_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             is_last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign is_last = (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (xfer_done) begin
                cnt_q <= cnt_q - ONE;
                if (is_last) en_q <= 1'b0;
            end
            if (ctl_wr) begin
                if (!ctl_en) begin
                    en_q <= 1'b0;
                end else if (!en_q && ctl_count != '0) begin
                    en_q  <= 1'b1;
                    cnt_q <= ctl_count;
                end
            end
        end
    end
endmodule

// File: rtl/dreq_gap.sv
module dreq_gap #(
    parameter int MIN_REL = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic xfer_done,
    output logic gap_ok
);
    localparam int GW = $clog2(MIN_REL + 1);
    localparam logic [GW-1:0] LIMIT = GW'(MIN_REL);

    logic [GW-1:0] free_q;

    always_ff @(posedge clk) begin
        if (rst)                 free_q <= LIMIT;
        else if (xfer_done)      free_q <= '0;
        else if (free_q < LIMIT) free_q <= free_q + GW'(1);
    end

    assign gap_ok = (free_q >= LIMIT);
endmodule

// File: rtl/dreq_accept_ctrl.sv
module dreq_accept_ctrl
    import dreq_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int MIN_REL     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_n,
    input  logic             ctl_wr,
    input  logic             ctl_en,
    input  logic             ctl_dly,
    input  logic [CNT_W-1:0] ctl_count,
    input  logic             bus_grant,
    output logic             bus_req,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic             done,
    output logic             pend,
    output logic             enabled,
    output logic [CNT_W-1:0] remain
);
    dreq_state_e state, nxt;
    logic        req_sync_n;
    logic        en_q;
    logic        is_last;
    logic        gap_ok;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (req_n),
        .dout (req_sync_n)
    );

    dreq_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_en    (ctl_en),
        .ctl_count (ctl_count),
        .xfer_done (wr_stb),
        .en_q      (en_q),
        .cnt_q     (remain),
        .is_last   (is_last)
    );

    dreq_gap #(.MIN_REL(MIN_REL)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .xfer_done (wr_stb),
        .gap_ok    (gap_ok)
    );

    assign enabled = en_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // outputs
    always_comb begin
        bus_req = 1'b0;
        rd_stb  = 1'b0;
        wr_stb  = 1'b0;
        done    = 1'b0;
        pend    = 1'b0;
        unique case (state)
            ST_HOLD:  pend = 1'b1;
            ST_WAIT:  bus_req = 1'b1;
            ST_READ: begin
                bus_req = 1'b1;
                rd_stb  = bus_grant && gap_ok;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                wr_stb  = bus_grant;
                done    = bus_grant && is_last;
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (en_q) nxt = ST_SAMPLE;
            ST_SAMPLE: begin
                if (!en_q)            nxt = ST_IDLE;
                else if (!req_sync_n) nxt = ST_HOLD;
            end
            ST_HOLD:   nxt = en_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: begin
                if (!en_q)          nxt = ST_IDLE;
                else if (bus_grant) nxt = ST_READ;
            end
            ST_READ:   if (rd_stb) nxt = ST_WRITE;
            ST_WRITE: begin
                if (wr_stb) begin
                    if (is_last || !en_q) nxt = ST_IDLE;
                    else if (ctl_dly)     nxt = ST_EXTEND;
                    else                  nxt = ST_SAMPLE;
                end
            end
            ST_EXTEND: nxt = en_q ? ST_SAMPLE : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/dreq_accept_chk.sv
module dreq_accept_chk #(
    parameter int CNT_W   = 16,
    parameter int MIN_REL = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_grant,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic             done,
    input logic             pend,
    input logic             enabled,
    input logic [CNT_W-1:0] remain
);
    logic [15:0] since_wr;
    logic        rd_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_wr <= 16'(MIN_REL);
            rd_seen  <= 1'b0;
        end else begin
            if (wr_stb)                  since_wr <= '0;
            else if (since_wr != 16'hFFFF) since_wr <= since_wr + 16'd1;
            if (rd_stb)      rd_seen <= 1'b1;
            else if (wr_stb) rd_seen <= 1'b0;
        end
    end

    // R5
    strobe_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> bus_grant);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    // R5
    read_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> rd_seen);

    // R3
    pend_single_chk: assert property (@(posedge clk) disable iff (rst)
        pend |=> !pend);

    // R7
    release_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |-> (since_wr >= 16'(MIN_REL)));

    // R8
    done_terminal_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!enabled && remain == '0));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind dreq_accept_ctrl dreq_accept_chk #(.CNT_W(CNT_W), .MIN_REL(MIN_REL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_grant (bus_grant),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .done      (done),
    .pend      (pend),
    .enabled   (enabled),
    .remain    (remain)
);

// File: tb/dreq_accept_ctrl_test.sv
module dreq_accept_ctrl_test;
    localparam int CNT_W   = 16;
    localparam int MIN_REL = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_n = 1'b1;
    logic             ctl_wr = 1'b0;
    logic             ctl_en = 1'b0;
    logic             ctl_dly = 1'b0;
    logic [CNT_W-1:0] ctl_count = '0;
    logic             bus_grant = 1'b0;
    logic             bus_req, rd_stb, wr_stb, done, pend, enabled;
    logic [CNT_W-1:0] remain;

    dreq_accept_ctrl #(.CNT_W(CNT_W), .MIN_REL(MIN_REL), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .req_n(req_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
        .ctl_dly(ctl_dly), .ctl_count(ctl_count), .bus_grant(bus_grant),
        .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done),
        .pend(pend), .enabled(enabled), .remain(remain)
    );

    always #2 clk = ~clk;

    int nchk = 0, nfail = 0, cyc = 0;
    // behavioural model: phase 0 idle,1 sample,2 hold,3 wait,4 read,5 write,6 extend
    int m_ph = 0, m_en = 0, m_cnt = 0, m_gap = MIN_REL, m_s1 = 1, m_s2 = 1;
    int n_wr = 0, n_done = 0, n_pend = 0, last_wr = -1, dmin = 0, dmax = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic clear_stats();
        n_wr = 0; n_done = 0; n_pend = 0; last_wr = -1; dmin = 1000; dmax = 0;
    endtask

    task automatic tick();
        int e_breq, e_rd, e_wr, e_done, e_pend, nph, ncnt, nen, ngap, s2;
        #1;
        e_breq = (m_ph == 3 || m_ph == 4 || m_ph == 5);
        e_rd   = (m_ph == 4 && bus_grant && m_gap >= MIN_REL);
        e_wr   = (m_ph == 5 && bus_grant);
        e_done = (e_wr && m_cnt == 1);
        e_pend = (m_ph == 2);
        chk(bus_req == e_breq, "R5 bus_req", bus_req, e_breq);
        chk(rd_stb == e_rd, "R5 rd_stb", rd_stb, e_rd);
        chk(wr_stb == e_wr, "R5 wr_stb", wr_stb, e_wr);
        chk(done == e_done, "R8 done", done, e_done);
        chk(pend == e_pend, "R3 pend", pend, e_pend);
        chk(enabled == m_en, "R2 enabled", enabled, m_en);
        chk(int'(remain) == m_cnt, "R8 remain", remain, m_cnt);
        if (rd_stb && last_wr >= 0) begin
            if (cyc - last_wr < dmin) dmin = cyc - last_wr;
            if (cyc - last_wr > dmax) dmax = cyc - last_wr;
        end
        if (wr_stb) begin n_wr++; last_wr = cyc; end
        if (done) n_done++;
        if (pend) n_pend++;
        s2 = m_s2; m_s2 = m_s1; m_s1 = req_n;
        nph = m_ph; ncnt = m_cnt; nen = m_en; ngap = m_gap;
        case (m_ph)
            0: if (m_en != 0) nph = 1;
            1: if (m_en == 0) nph = 0; else if (s2 == 0) nph = 2;
            2: nph = (m_en != 0) ? 3 : 0;
            3: if (m_en == 0) nph = 0; else if (bus_grant) nph = 4;
            4: if (e_rd != 0) nph = 5;
            5: if (e_wr != 0) begin
                   if (m_cnt == 1 || m_en == 0) nph = 0;
                   else nph = ctl_dly ? 6 : 1;
               end
            default: nph = (m_en != 0) ? 1 : 0;
        endcase
        if (e_wr != 0) begin ncnt = m_cnt - 1; if (m_cnt == 1) nen = 0; end
        if (ctl_wr) begin
            if (!ctl_en) nen = 0;
            else if (m_en == 0 && ctl_count != 0) begin nen = 1; ncnt = int'(ctl_count); end
        end
        if (e_wr != 0) ngap = 0; else if (m_gap < MIN_REL) ngap = m_gap + 1;
        m_ph = nph; m_cnt = ncnt; m_en = nen; m_gap = ngap;
        cyc++;
        @(negedge clk);
    endtask

    task automatic ctl_write(input bit en, input int count);
        ctl_wr = 1'b1; ctl_en = en; ctl_count = CNT_W'(count);
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R10: reset state
        #1;
        chk(enabled == 0 && remain == 0, "R1 reset enable/count", int'(remain), 0);
        chk(!bus_req && !rd_stb && !wr_stb && !done && !pend, "R10 reset strobes", int'(rd_stb), 0);
        @(negedge clk);

        // R2: zero count enable ignored
        clear_stats();
        ctl_write(1'b1, 0);
        tick();
        chk(enabled == 0, "R2 zero count ignored", enabled, 0);

        // R6 R7 R8: held request, no extension
        clear_stats();
        req_n = 1'b0; bus_grant = 1'b1; ctl_dly = 1'b0;
        run(3);
        ctl_write(1'b1, 3);
        run(30);
        chk(n_wr == 3, "R8 write count dly0", n_wr, 3);
        chk(n_done == 1, "R8 done pulses", n_done, 1);
        chk(dmin == 4 && dmax == 4, "R6 spacing dly0", dmax, 4);
        chk(dmin - 1 >= MIN_REL, "R7 free cycles", dmin - 1, MIN_REL);
        chk(enabled == 0 && remain == 0, "R8 terminal", int'(remain), 0);

        // R6: extended window
        clear_stats();
        ctl_dly = 1'b1;
        ctl_write(1'b1, 3);
        run(30);
        chk(n_wr == 3, "R8 write count dly1", n_wr, 3);
        chk(dmin == 5 && dmax == 5, "R6 spacing dly1", dmax, 5);

        // R5: grant stalls
        clear_stats();
        ctl_write(1'b1, 4);
        for (int i = 0; i < 80; i++) begin
            bus_grant = (i % 3) != 0;
            tick();
        end
        bus_grant = 1'b1;
        chk(n_wr == 4, "R5 transfers under stalls", n_wr, 4);

        // R4: low level only inside clearance window
        clear_stats();
        req_n = 1'b1; ctl_dly = 1'b0;
        run(4);
        ctl_write(1'b1, 2);
        req_n = 1'b0;
        run(5);
        req_n = 1'b1;
        run(20);
        chk(n_wr == 1, "R4 single transfer", n_wr, 1);
        chk(n_pend == 1, "R4 single pend", n_pend, 1);
        // R2: enable write while enabled ignored
        ctl_write(1'b1, 9);
        tick();
        chk(int'(remain) == 1, "R2 reload ignored", int'(remain), 1);
        ctl_write(1'b0, 0);
        tick();
        chk(enabled == 0, "R2 disable", enabled, 0);

        // R9: disable at read entry, pair completes
        clear_stats();
        bus_grant = 1'b0; req_n = 1'b0;
        ctl_write(1'b1, 5);
        for (int i = 0; i < 40 && !bus_req; i++) tick();
        bus_grant = 1'b1;
        ctl_write(1'b0, 0);
        run(20);
        chk(n_wr == 1, "R9 pair completes", n_wr, 1);
        chk(int'(remain) == 4 && enabled == 0, "R9 idle after pair", int'(remain), 4);

        // R9: disable before read, no strobes
        clear_stats();
        bus_grant = 1'b0;
        ctl_write(1'b1, 5);
        for (int i = 0; i < 40 && !bus_req; i++) tick();
        ctl_write(1'b0, 0);
        bus_grant = 1'b1;
        run(20);
        chk(n_wr == 0, "R9 abandoned", n_wr, 0);
        chk(!bus_req, "R9 bus released", bus_req, 0);

        // R10: reset mid-transfer
        ctl_write(1'b1, 5);
        run(6);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(enabled == 0 && remain == 0 && !bus_req && !pend, "R10 sync reset", int'(remain), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule